// File: doc/BRIEF.md
# Source Stream Word Emitter

This block sits between the read-data FIFO of a memory-to-stream DMA source channel and its outgoing valid/ready stream. Software (or a command sequencer) starts a command by giving a length in 32-bit words. The block then moves exactly that many words from the FIFO to the stream. It counts down the remaining words, and it can flag the final word of the command as the end of a message.

A stream-pause input freezes all movement between FIFO and stream. Counters and data stay where they are, so the command picks up again at the same word once the pause is lifted. An optional byte-order reversal is applied to each outgoing word.

Every word that crosses the stream handshake is added into a running 32-bit checksum. The sum keeps accumulating across commands until it is explicitly cleared.

Top module: `srcstrm_emitter`

## Requirements
- R1: After reset, busy, done, out_valid and out_last are 0 and words_left and csum are 0.
- R2: A cmd_go pulse with a nonzero cmd_words while idle loads words_left with that count of 32-bit words and makes busy 1 on the next cycle. A cmd_go with cmd_words equal to 0 leaves the block idle.
- R3: words_left drops by one on each cycle where out_valid and out_ready are both 1. When it reaches 0, done is 1 for exactly one cycle and busy returns to 0. The number of words emitted equals the programmed count.
- R4: If cmd_mark_last was 1 when the command was accepted, out_last is 1 together with out_valid on the final word of that command. It is 0 on every other word, and always 0 when cmd_mark_last was 0.
- R5: While pause_stream is 1, out_valid and fifo_pop stay 0 and words_left holds. After it returns to 0, the remaining words follow in their original order, with none lost or repeated.
- R6: csum is the sum, modulo 2^32, of the raw FIFO words taken on handshake cycles. It is not reset between commands.
- R7: A csum_clear pulse makes csum 0 on the next cycle. A word handed over in the same cycle as the clear is not added.
- R8: With swap_bytes at 1, out_data carries the FIFO word with its four bytes in reverse order (bits 7:0 move to 31:24, and so on). At 0, out_data equals the FIFO word. The checksum always uses the unswapped word.
- R9: A cmd_go while busy is ignored: words_left and the last-word marking of the running command are unchanged.
- R10: While idle, out_valid and fifo_pop stay 0 even when fifo_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Start a command (one-cycle pulse) |
| cmd_words | input | CNT_W | Command length in 32-bit words |
| cmd_mark_last | input | 1 | Flag the final word of this command |
| pause_stream | input | 1 | Freeze FIFO-to-stream movement |
| swap_bytes | input | 1 | Reverse byte order of outgoing words |
| csum_clear | input | 1 | Reset the checksum to zero |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_pop | output | 1 | Head word consumed this cycle |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 32 | Stream word |
| out_last | output | 1 | End-of-message marker |
| out_ready | input | 1 | Stream sink accepts |
| words_left | output | CNT_W | Words still to send |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| csum | output | 32 | Running checksum |

## Verification
The bench targets the final word of each command. A design with an off-by-one counter would flag the wrong word as last, or emit one word too many or too few. Pauses are dropped in mid-command with a throttled sink, so a design that lets a word leak or advances the count while frozen shows up as a gap or a duplicate in the scoreboard.

A second go arrives while a command is stalled. A design that reloads would run on to twenty words or lose the end marker. A clear lands on a cycle with a live handshake, and an overflowing pair of words checks the modulo wrap. Zero-length and idle-with-data cases catch a block that starts spuriously.

// File: rtl/emit_pkg.sv
package emit_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int NBYTES = WORD_W / BYTE_W;
  typedef logic [WORD_W-1:0] word_t;

  // reverse the order of the bytes in a word
  function automatic word_t flip_bytes(input word_t w);
    word_t r;
    for (int i = 0; i < NBYTES; i++) begin
      r[i*BYTE_W +: BYTE_W] = w[(NBYTES-1-i)*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  // one checksum step, wraps modulo 2^WORD_W
  function automatic word_t csum_step(input word_t acc, input word_t w);
    return acc + w;
  endfunction
endpackage

// File: rtl/emit_count.sv
module emit_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] words,
  input  logic             mark_in,
  input  logic             fire,
  output logic [CNT_W-1:0] left,
  output logic             mark,
  output logic             busy,
  output logic             final_beat,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic accept;
  assign busy       = (left != '0);
  assign final_beat = (left == ONE);
  assign accept     = start && !busy && (words != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      mark <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fire && final_beat;
      if (accept) begin
        left <= words;
        mark <= mark_in;
      end else if (fire) begin
        left <= left - ONE;
      end
    end
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> left == $past(left) - ONE);
  a_r3_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && left == ONE) |=> (done && !busy));
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fire) |=> (left == $past(left) && mark == $past(mark)));
  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && words == '0) |=> !busy);
endmodule

// File: rtl/emit_lane.sv
module emit_lane
  import emit_pkg::*;
(
  input  word_t data_in,
  input  logic  swap,
  output word_t data_out
);
  word_t flipped;
  assign flipped = flip_bytes(data_in);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign data_out[g*BYTE_W +: BYTE_W] =
      swap ? flipped[g*BYTE_W +: BYTE_W] : data_in[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/emit_csum.sv
module emit_csum
  import emit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  fire,
  input  word_t word,
  output word_t sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sum <= '0;
    else if (clr)  sum <= '0;
    else if (fire) sum <= csum_step(sum, word);
  end

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sum == '0);
  a_r6_accum: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> sum == $past(sum) + $past(word));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(sum));
endmodule

// File: rtl/srcstrm_emitter.sv
module srcstrm_emitter
  import emit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_go,
  input  logic [CNT_W-1:0]     cmd_words,
  input  logic                 cmd_mark_last,
  input  logic                 pause_stream,
  input  logic                 swap_bytes,
  input  logic                 csum_clear,
  input  logic                 fifo_valid,
  input  logic [WORD_W-1:0]    fifo_data,
  output logic                 fifo_pop,
  output logic                 out_valid,
  output logic [WORD_W-1:0]    out_data,
  output logic                 out_last,
  input  logic                 out_ready,
  output logic [CNT_W-1:0]     words_left,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_W-1:0]    csum
);
  logic gate, fire, mark, final_beat;

  assign gate      = busy && !pause_stream;
  assign out_valid = gate && fifo_valid;
  assign fire      = out_valid && out_ready;
  assign fifo_pop  = fire;
  assign out_last  = out_valid && final_beat && mark;

  emit_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .start(cmd_go), .words(cmd_words),
    .mark_in(cmd_mark_last), .fire(fire), .left(words_left), .mark(mark),
    .busy(busy), .final_beat(final_beat), .done(done)
  );

  emit_lane u_lane (.data_in(fifo_data), .swap(swap_bytes), .data_out(out_data));

  emit_csum u_csum (
    .clk(clk), .rst_n(rst_n), .clr(csum_clear), .fire(fire),
    .word(fifo_data), .sum(csum)
  );

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !fifo_pop && !out_last));
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_stream && busy) |=> $stable(words_left));
  a_r4_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> done);
endmodule

// File: tb/srcstrm_emitter_bench.sv
`timescale 1ns/1ps
module srcstrm_emitter_bench;
  localparam int CW = 16;
  localparam int RING = 256;

  logic clk = 0, rst_n = 0;
  logic cmd_go = 0, cmd_mark_last = 0, pause_stream = 0, swap_bytes = 0, csum_clear = 0;
  logic [CW-1:0] cmd_words = '0;
  logic fifo_valid = 0, out_ready = 0;
  logic [31:0] fifo_data = '0;
  logic fifo_pop, out_valid, out_last, busy, done;
  logic [31:0] out_data, csum;
  logic [CW-1:0] words_left;

  always #2.5 clk = ~clk;

  srcstrm_emitter #(.CNT_W(CW)) u_srcstrm_emitter (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_words(cmd_words),
    .cmd_mark_last(cmd_mark_last), .pause_stream(pause_stream),
    .swap_bytes(swap_bytes), .csum_clear(csum_clear), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .words_left(words_left), .busy(busy), .done(done), .csum(csum)
  );

  // source ring (written by tasks, read by the FIFO model)
  logic [31:0] src_mem [RING];
  int wr_ptr = 0, rd_ptr = 0;
  // scoreboard ring (written by tasks, read by the monitor)
  logic [31:0] exp_data [RING];
  logic        exp_last [RING];
  int exp_wr = 0, exp_rd = 0;
  logic [31:0] exp_csum = '0, mon_csum = '0;
  int done_cnt = 0;
  int nchk = 0, nfail = 0, mchk = 0, mfail = 0;
  int cyc = 0;
  bit pop_seen = 0, gap_mode = 0, rdy_mode = 0, hold_rdy = 0;

  // FIFO and sink model
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (pop_seen) rd_ptr = rd_ptr + 1;
    fifo_valid = (wr_ptr != rd_ptr) && !(gap_mode && (cyc % 3 == 0));
    fifo_data  = src_mem[rd_ptr % RING];
    out_ready  = !hold_rdy && !(rdy_mode && (cyc % 4 == 1));
  end

  // monitor: pops expected words as the design hands them over
  always @(negedge clk) begin
    pop_seen = fifo_valid && fifo_pop;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        mchk++;
        if (exp_rd == exp_wr) begin
          mfail++;
          $display("FAIL R3 extra word: actual %0h expected none", out_data);
        end else begin
          if (out_data !== exp_data[exp_rd % RING] || out_last !== exp_last[exp_rd % RING]) begin
            mfail++;
            $display("FAIL R4/R8 word %0d: actual %0h last %0b expected %0h last %0b",
                     exp_rd, out_data, out_last, exp_data[exp_rd % RING], exp_last[exp_rd % RING]);
          end
          exp_rd++;
        end
      end
      if (pause_stream) begin
        mchk++;
        if (out_valid || fifo_pop) begin
          mfail++;
          $display("FAIL R5 paused: actual valid %0b pop %0b expected 0 0", out_valid, fifo_pop);
        end
      end
      if (!busy && fifo_valid) begin
        mchk++;
        if (out_valid || fifo_pop) begin
          mfail++;
          $display("FAIL R10 idle: actual valid %0b pop %0b expected 0 0", out_valid, fifo_pop);
        end
      end
      if (csum_clear) mon_csum = '0;
      else if (out_valid && out_ready) mon_csum = mon_csum + fifo_data;
      if (done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] w, input bit last);
    src_mem[wr_ptr % RING] = w;
    exp_data[exp_wr % RING] = swap_bytes ? {<<8{w}} : w;
    exp_last[exp_wr % RING] = last;
    exp_csum = exp_csum + w;
    wr_ptr++;
    exp_wr++;
  endtask

  task automatic load_words(input int n, input bit mark, input int seed);
    for (int i = 0; i < n; i++)
      push_word(32'h0101_0101 * seed + 32'h0013_5700 * i + 32'h2A, mark && (i == n - 1));
  endtask

  task automatic go(input int n, input bit mark);
    @(posedge clk); #2;
    cmd_go = 1; cmd_words = CW'(n); cmd_mark_last = mark;
    @(posedge clk); #2;
    cmd_go = 0; cmd_mark_last = 0;
  endtask

  task automatic wait_idle(input string req, input int done_before);
    int t = 0;
    @(negedge clk);
    while (busy && t < 2000) begin @(negedge clk); t++; end
    @(posedge clk); #2;
    chk(t < 2000, {req, " timeout"}, 32'(t), 32'd2000);
    chk(done_cnt == done_before + 1, {req, " R3 done pulses"}, 32'(done_cnt), 32'(done_before + 1));
    chk(exp_rd == exp_wr, {req, " R3 word count"}, 32'(exp_rd), 32'(exp_wr));
    chk(words_left == '0, {req, " R3 words_left"}, 32'(words_left), 32'd0);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nchk + mchk - nfail - mfail, nchk + mchk + 1);
      $finish;
    end
  end

  initial begin
    int d0;
    logic [CW-1:0] wl0;
    int rp0;
    cycles(3);
    rst_n = 1;
    cycles(1);
    // R1 reset state
    chk(!busy && !done && !out_valid && !out_last, "R1 flags", {busy, done, out_valid, out_last}, 0);
    chk(words_left == '0 && csum == '0, "R1 counters", csum, 0);

    // R10: data waiting, no command
    load_words(4, 1, 1);
    cycles(5);
    chk(fifo_valid && !out_valid && rd_ptr == 0, "R10 idle hold", 32'(rd_ptr), 0);

    // R2 R3 R4 R6 basic command with end marker
    d0 = done_cnt;
    go(4, 1);
    wait_idle("R2 basic", d0);
    chk(csum == exp_csum, "R6 sum after first", csum, exp_csum);

    // R2 zero-length command
    d0 = done_cnt;
    go(0, 1);
    cycles(3);
    chk(!busy && done_cnt == d0, "R2 zero length", {31'b0, busy}, 0);

    // R4 no marker, throttled source and sink, R6 accumulates
    gap_mode = 1; rdy_mode = 1;
    load_words(7, 0, 2);
    d0 = done_cnt;
    go(7, 0);
    wait_idle("R4 unmarked", d0);
    chk(csum == exp_csum, "R6 accumulate", csum, exp_csum);

    // R8 byte swap, checksum on raw words
    swap_bytes = 1;
    load_words(5, 1, 3);
    d0 = done_cnt;
    go(5, 1);
    wait_idle("R8 swap", d0);
    chk(csum == exp_csum, "R8 raw checksum", csum, exp_csum);
    swap_bytes = 0;

    // R5 pause in mid-command
    load_words(6, 1, 4);
    d0 = done_cnt;
    go(6, 1);
    cycles(2);
    pause_stream = 1;
    @(negedge clk);
    wl0 = words_left; rp0 = rd_ptr;
    chk(busy, "R5 still busy at pause", {31'b0, busy}, 1);
    repeat (6) @(negedge clk);
    chk(words_left == wl0 && rd_ptr == rp0, "R5 frozen", 32'(words_left), 32'(wl0));
    @(posedge clk); #2;
    pause_stream = 0;
    wait_idle("R5 resume", d0);
    gap_mode = 0; rdy_mode = 0;

    // R9 second go while busy
    hold_rdy = 1;
    load_words(5, 1, 5);
    d0 = done_cnt;
    go(5, 1);
    cycles(2);
    go(20, 0);
    @(negedge clk);
    chk(words_left == CW'(5), "R9 count kept", 32'(words_left), 32'd5);
    @(posedge clk); #2;
    hold_rdy = 0;
    wait_idle("R9 ignore", d0);
    chk(!busy, "R9 no restart", {31'b0, busy}, 0);

    // R7 clear while idle
    @(posedge clk); #2; csum_clear = 1;
    @(posedge clk); #2; csum_clear = 0;
    exp_csum = '0;
    chk(csum == '0, "R7 idle clear", csum, 0);

    // R7 clear during live handshakes
    load_words(8, 0, 6);
    d0 = done_cnt;
    go(8, 0);
    cycles(2);
    csum_clear = 1;
    @(posedge clk); #2; csum_clear = 0;
    wait_idle("R7 live", d0);
    chk(csum == mon_csum, "R7 clear drops same-cycle word", csum, mon_csum);

    // R6 modulo wrap
    @(posedge clk); #2; csum_clear = 1;
    @(posedge clk); #2; csum_clear = 0;
    exp_csum = '0;
    push_word(32'hFFFF_FFF0, 0);
    push_word(32'h0000_0020, 1);
    d0 = done_cnt;
    go(2, 1);
    wait_idle("R6 wrap", d0);
    chk(csum == 32'h10, "R6 wrap value", csum, 32'h10);

    cycles(2);
    $display("%0d/%0d checks passed", nchk + mchk - nfail - mfail, nchk + mchk);
    $finish;
  end
endmodule